// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (twelve by default). Software reaches it through a simple 32-bit register port: a write strobe with address and data, and combinational read data selected by the same address. Each pin has an output data bit and an output enable bit. The pin's input level passes through a two-flop synchronizer before it can be read back or used for interrupt detection.

Every pin can raise a level-sensitive interrupt. The active polarity is chosen per pin. While a pin sits at its active level, its status bit is latched to one. Software clears status by writing ones. If the source is still active after the clear, the bit sets again on the following clock. An enable mask gates the status bits into a single combined interrupt line. A separate 32-bit mux-control word is stored and driven out unchanged to the pad multiplexing logic, which lies outside this block.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, every register reads zero, `padOe` and `padOut` are zero, `muxCtl` is zero and `irqOut` is low.
- R2: The output data register at byte offset 0x00 drives `padOut` bit n for pin n. The output enable register at 0x04 drives `padOe` bit n; 1 drives the pad and 0 releases it (high impedance). Both read back what was written.
- R3: Offset 0x08 reads the pin inputs after a two-register synchronizer. A change on `padIn` shows up in the read after the second clock edge. Writes to 0x08 are ignored.
- R4: Pin polarity lives in two type registers: 0x10 for pins 0–7 and 0x18 for pins 8–11. Pin n uses bit 4×(n mod 8). A 0 makes the pin active while high and a 1 makes it active while low. All 32 bits of each type register are stored and read back, but the other bits have no effect.
- R5: The status register at 0x0C is write-one-to-clear. A written 1 clears the bit on that clock edge. A written 0 leaves the bit unchanged.
- R6: On each clock a pin whose synchronized input is at its active level sets its status bit. This happens whether or not the pin is enabled. When a clear and an active level meet on the same edge, the clear wins, and the bit sets again on the next edge if the level is still active.
- R7: In the enable register at 0x14, a 1 unmasks the pin. `irqOut` is the OR over all pins of status AND enable.
- R8: The mux-control register at 0x1C stores all 32 bits, reads them back, and drives them on `muxCtl`.
- R9: Reads of any other address, including unaligned ones, return zero, and writes to such addresses change nothing. Unused upper bits of the per-pin registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regAddr | input | 8 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| padIn | input | 12 | Raw pin input levels |
| padOut | output | 12 | Pad output values |
| padOe | output | 12 | Pad drive enables; 0 releases the pad |
| muxCtl | output | 32 | Mux-control word for the external pad mux |
| irqOut | output | 1 | Combined interrupt |

## Verification
The critical collision is a write-one-to-clear of a status bit landing on the same edge as a level that is still active on that pin. The clear must win for exactly one cycle, and the bit must reappear on the next edge. A directed sequence holds pin 0 high, enables it, clears it, and reads status on the two cycles that follow, expecting 0 then 1. Random traffic then mixes status writes, type and enable writes, and pin toggles in arbitrary cycles, and compares every cycle against a cycle-level reference model.

// File: rtl/gpio_lvl_pkg.sv
`timescale 1ns/1ps
package gpio_lvl_pkg;

  localparam int OFS_OUT    = 'h00;
  localparam int OFS_OE     = 'h04;
  localparam int OFS_IN     = 'h08;
  localparam int OFS_STAT   = 'h0C;
  localparam int OFS_TYPELO = 'h10;
  localparam int OFS_EN     = 'h14;
  localparam int OFS_TYPEHI = 'h18;
  localparam int OFS_MUX    = 'h1C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OE, SEL_IN, SEL_STAT,
    SEL_TYPELO, SEL_EN, SEL_TYPEHI, SEL_MUX
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrOe;
    logic   wrStat;
    logic   wrTypeLo;
    logic   wrEn;
    logic   wrTypeHi;
    logic   wrMux;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_lvl_ctrl.sv
`timescale 1ns/1ps
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (regAddr)
      ADDR_W'(OFS_OUT): begin
        strb.rdSel = SEL_OUT;
        strb.wrOut = regWrEn;
      end
      ADDR_W'(OFS_OE): begin
        strb.rdSel = SEL_OE;
        strb.wrOe  = regWrEn;
      end
      ADDR_W'(OFS_IN): begin
        strb.rdSel = SEL_IN;
      end
      ADDR_W'(OFS_STAT): begin
        strb.rdSel  = SEL_STAT;
        strb.wrStat = regWrEn;
      end
      ADDR_W'(OFS_TYPELO): begin
        strb.rdSel    = SEL_TYPELO;
        strb.wrTypeLo = regWrEn;
      end
      ADDR_W'(OFS_EN): begin
        strb.rdSel = SEL_EN;
        strb.wrEn  = regWrEn;
      end
      ADDR_W'(OFS_TYPEHI): begin
        strb.rdSel    = SEL_TYPEHI;
        strb.wrTypeHi = regWrEn;
      end
      ADDR_W'(OFS_MUX): begin
        strb.rdSel = SEL_MUX;
        strb.wrMux = regWrEn;
      end
      default: ;
    endcase
  end

  logic [6:0] wrVec;
  assign wrVec = {strb.wrOut, strb.wrOe, strb.wrStat, strb.wrTypeLo,
                  strb.wrEn, strb.wrTypeHi, strb.wrMux};

  // R9: at most one register is written, and none without the write strobe
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));
  p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (wrVec == '0));

endmodule

// File: rtl/gpio_lvl_dpath.sv
`timescale 1ns/1ps
module gpio_lvl_dpath
  import gpio_lvl_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [DATA_W-1:0]   muxCtl,
  output logic                irqOut
);

  localparam int POL_STRIDE    = 4;
  localparam int PINS_PER_TYPE = DATA_W / POL_STRIDE;

  logic [NUM_PINS-1:0] outQ, oeQ, enQ, statQ;
  logic [NUM_PINS-1:0] syncA, syncB;
  logic [DATA_W-1:0]   typeLoQ, typeHiQ, muxQ;
  logic [NUM_PINS-1:0] polLow, activeVec, clrVec;

  // two-flop input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // plain read/write registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ    <= '0;
      oeQ     <= '0;
      enQ     <= '0;
      typeLoQ <= '0;
      typeHiQ <= '0;
      muxQ    <= '0;
    end else begin
      if (strb.wrOut)    outQ    <= wrData[NUM_PINS-1:0];
      if (strb.wrOe)     oeQ     <= wrData[NUM_PINS-1:0];
      if (strb.wrEn)     enQ     <= wrData[NUM_PINS-1:0];
      if (strb.wrTypeLo) typeLoQ <= wrData;
      if (strb.wrTypeHi) typeHiQ <= wrData;
      if (strb.wrMux)    muxQ    <= wrData;
    end
  end

  // polarity select: one bit per pin at a fixed stride, split over two words
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pol
    if (p < PINS_PER_TYPE) begin : g_lo
      assign polLow[p] = typeLoQ[POL_STRIDE*p];
    end else begin : g_hi
      assign polLow[p] = typeHiQ[POL_STRIDE*(p-PINS_PER_TYPE)];
    end
  end

  assign activeVec = syncB ^ polLow;
  assign clrVec    = strb.wrStat ? wrData[NUM_PINS-1:0] : '0;

  // level-latched status; clear has priority on the edge it is written
  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ | activeVec) & ~clrVec;
  end

  assign irqOut = |(statQ & enQ);
  assign padOut = outQ;
  assign padOe  = oeQ;
  assign muxCtl = muxQ;

  always_comb begin
    case (strb.rdSel)
      SEL_OUT:    rdData = DATA_W'(outQ);
      SEL_OE:     rdData = DATA_W'(oeQ);
      SEL_IN:     rdData = DATA_W'(syncB);
      SEL_STAT:   rdData = DATA_W'(statQ);
      SEL_TYPELO: rdData = typeLoQ;
      SEL_EN:     rdData = DATA_W'(enQ);
      SEL_TYPEHI: rdData = typeHiQ;
      SEL_MUX:    rdData = muxQ;
      default:    rdData = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      clrVec[i] |=> !statQ[i]);
    p_w1c_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (statQ[i] && !clrVec[i]) |=> statQ[i]);
    p_level_set_r6: assert property (@(posedge clk) disable iff (!rstN)
      (activeVec[i] && !clrVec[i]) |=> statQ[i]);
  end

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrOe |=> $stable(oeQ));
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(strb.wrStat || strb.wrEn));
  p_mux_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMux |=> $stable(muxQ));

endmodule

// File: rtl/gpio_lvl_irq.sv
`timescale 1ns/1ps
module gpio_lvl_irq
  import gpio_lvl_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [DATA_W-1:0]   muxCtl,
  output logic                irqOut
);

  regStrobe_t strb;

  gpio_lvl_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  gpio_lvl_dpath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .padIn  (padIn),
    .rdData (regRdData),
    .padOut (padOut),
    .padOe  (padOe),
    .muxCtl (muxCtl),
    .irqOut (irqOut)
  );

  // R1: nothing is driven or signalled while reset holds
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0 && !irqOut && muxCtl == '0));

endmodule

// File: tb/gpio_lvl_irq_tb_top.sv
`timescale 1ns/1ps
module gpio_lvl_irq_tb_top;

  localparam int NP = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe;
  logic [31:0] muxCtl;
  logic        irqOut;

  always #10 clk = ~clk;

  gpio_lvl_irq dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .muxCtl(muxCtl), .irqOut(irqOut)
  );

  int nVec = 0;
  int nBad = 0;

  // reference model, advanced on each rising edge from the requirements
  logic [NP-1:0] mOut, mOe, mEn, mStat, mS1, mS2;
  logic [31:0]   mTypeLo, mTypeHi, mMux;

  function automatic logic pinPolLow(int n);
    return (n < 8) ? mTypeLo[4*n] : mTypeHi[4*(n-8)];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOut = '0; mOe = '0; mEn = '0; mStat = '0; mS1 = '0; mS2 = '0;
      mTypeLo = '0; mTypeHi = '0; mMux = '0;
    end else begin
      logic [NP-1:0] act, clr;
      for (int n = 0; n < NP; n++) act[n] = mS2[n] ^ pinPolLow(n);
      clr = (regWrEn && regAddr == 8'h0C) ? regWrData[NP-1:0] : '0;
      mStat = (mStat | act) & ~clr;
      if (regWrEn) begin
        case (regAddr)
          8'h00: mOut = regWrData[NP-1:0];
          8'h04: mOe = regWrData[NP-1:0];
          8'h10: mTypeLo = regWrData;
          8'h14: mEn = regWrData[NP-1:0];
          8'h18: mTypeHi = regWrData;
          8'h1C: mMux = regWrData;
          default: ;
        endcase
      end
      mS2 = mS1;
      mS1 = padIn;
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return 32'(mOut);
      8'h04: return 32'(mOe);
      8'h08: return 32'(mS2);
      8'h0C: return 32'(mStat);
      8'h10: return mTypeLo;
      8'h14: return 32'(mEn);
      8'h18: return mTypeHi;
      8'h1C: return mMux;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R2";
      8'h08: return "R3";
      8'h0C: return "R5/R6";
      8'h10, 8'h18: return "R4";
      8'h14: return "R7";
      8'h1C: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk(reqOf(regAddr), "read", regRdData, expRead(regAddr));
    chk("R2", "padOut", 32'(padOut), 32'(mOut));
    chk("R2", "padOe", 32'(padOe), 32'(mOe));
    chk("R8", "muxCtl", muxCtl, mMux);
    chk("R7", "irqOut", 32'(irqOut), 32'(|(mStat & mEn)));
  endtask

  // drive one cycle at the falling edge, then check away from the edge
  task automatic drive(logic wr, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d;
    #2 checkAll();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and output
    for (int a = 0; a < 32; a += 4) begin
      drive(0, 8'(a), 0);
      chk("R1", "reset read", regRdData, 32'h0);
    end
    chk("R1", "reset padOe", 32'(padOe), 32'h0);
    chk("R1", "reset irqOut", 32'(irqOut), 32'h0);

    // R2: output data and enable
    drive(1, 8'h00, 32'hFFFF_FABC);
    drive(1, 8'h04, 32'h0000_00F0);
    drive(0, 8'h00, 0);
    chk("R2", "out readback masked", regRdData, 32'h0000_0ABC);
    chk("R2", "padOe", 32'(padOe), 32'h0F0);

    // R3: synchronizer latency and ignored write
    padIn = 12'h800;
    drive(1, 8'h08, 32'hFFFF_FFFF);
    chk("R3", "input before sync", regRdData, 32'h0);
    drive(0, 8'h08, 0);
    chk("R3", "input after two edges", regRdData, 32'h800);
    padIn = 12'h000;
    repeat (3) drive(1, 8'h0C, 32'hFFF);

    // R6 with R5: clear while level still active, clear wins then re-sets
    padIn = 12'h001;
    drive(1, 8'h14, 32'h001);
    repeat (4) drive(0, 8'h0C, 0);
    chk("R6", "status latched", regRdData, 32'h1);
    chk("R7", "irq raised", 32'(irqOut), 32'h1);
    drive(1, 8'h0C, 32'h0000_0001);
    drive(0, 8'h0C, 0);
    chk("R6", "cleared same edge", regRdData, 32'h0);
    drive(0, 8'h0C, 0);
    chk("R6", "re-set next edge", regRdData, 32'h1);

    // R5: writing zero keeps the bit
    drive(1, 8'h0C, 32'h0);
    drive(0, 8'h0C, 0);
    chk("R5", "zero write keeps", regRdData, 32'h1);

    // R4: active-low on pin 9 via high type word bit 4, other bits inert
    drive(1, 8'h18, 32'h0000_0010);
    drive(1, 8'h10, 32'hEEEE_EEEE);
    repeat (2) drive(0, 8'h0C, 0);
    chk("R4", "pin9 low active", regRdData, 32'h201);
    drive(0, 8'h10, 0);
    chk("R4", "type bits stored", regRdData, 32'hEEEE_EEEE);

    // R6: status latches while masked; R7 masks the output
    drive(1, 8'h14, 32'h0);
    drive(0, 8'h14, 0);
    chk("R7", "masked irq", 32'(irqOut), 32'h0);

    // R8 and R9
    drive(1, 8'h1C, 32'hDEAD_BEEF);
    drive(0, 8'h1C, 0);
    chk("R8", "mux readback", regRdData, 32'hDEAD_BEEF);
    drive(1, 8'h20, 32'h1234_5678);
    chk("R9", "unmapped read", regRdData, 32'h0);
    drive(1, 8'h01, 32'hFFFF_FFFF);
    chk("R9", "unaligned read", regRdData, 32'h0);
    drive(0, 8'h00, 0);
    chk("R9", "unaligned write ignored", regRdData, 32'h0000_0ABC);

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      if ($urandom_range(7) == 0) padIn = NP'($urandom);
      a = ($urandom_range(9) == 0) ? 8'($urandom) : 8'($urandom_range(9) * 4);
      drive(($urandom_range(2) == 0), a, $urandom);
    end

    finishRun();
  end

endmodule